// File: doc/BRIEF.md
# Dual-Rail Bias Start-Up Sequencer

This block orders the start-up of an isolated bias supply that produces a positive and a negative rail, and then watches over it. It does nothing until the input supply is above its undervoltage limit and enable is high. It then ramps the positive rail under a timeout. When that rail crosses its own undervoltage level, the block runs a one-cycle status check and fires one diagnostic current pulse. Once the positive rail is in regulation, it starts the negative rail with a low peak-current limit and raises the limit once the negative rail passes a phase threshold.

Two timers start together when the negative ramp begins. One is the negative-rail timeout and the other is the power-good delay. Power-good is raised only after the delay has run out and the negative rail has passed its undervoltage point. A timeout or a failed check shuts the supply down and starts a restart wait. When that wait ends, a new attempt begins. This repeats for as long as the fault persists. Dropping enable or losing the input supply sends the block straight back to idle at any time.

Top module: `bias_startup_seq`

## Requirements
- R1: The ramp enable output rises on the first clock after `vin_ok` and `en` are both sampled high while idle, and stays low while either is low.
- R2: If the positive rail has not progressed into the negative ramp when `SS_CYC` cycles of positive ramping have elapsed, counted from the first ramp cycle, the block enters shutdown and raises the fault flag on the next clock.
- R3: The status check takes the single cycle that follows `pos_uvlo_ok` being sampled during the positive ramp. If `chk_fail` is high in that cycle, the block shuts down. Otherwise `diag_pulse` is high for exactly one cycle.
- R4: The negative ramp starts only on the clock after `pos_reg` is sampled high while the block waits for regulation. At that point `ipk_sel` moves from off (2'b00) to low peak current (2'b01).
- R5: During the negative ramp, `ipk_sel` becomes high peak current (2'b10) on the clock after `neg_phase_ok` is first sampled high, and it stays high until the ramp ends.
- R6: If `neg_uvp_ok` has not been seen by the `NEG_CYC`-th cycle of the negative ramp, the block shuts down with the fault flag set.
- R7: `pgood` rises on the clock after a negative-ramp cycle in which at least `PG_CYC` cycles have elapsed and `neg_uvp_ok` has been seen. While `pgood` is high, `ipk_sel` reads 2'b10.
- R8: `shutdown` stays high for exactly `RST_CYC` cycles. After it falls, one idle cycle follows and then a new ramp begins, over and over while the fault persists. While `shutdown` is high, ramp enable is low and `ipk_sel` reads 2'b00.
- R9: Sampling `en` low or `vin_ok` low in any state returns the block to idle on the next clock. This clears `pgood` and `shutdown` and does not start a restart wait.
- R10: The fault flag is set on entry to shutdown. It holds through the restart wait and through idle, and it clears on the first clock of a new ramp.
- R11: While reset is held, every output is low and `ipk_sel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_ok | input | 1 | Input supply above its undervoltage limit |
| en | input | 1 | Start enable |
| pos_uvlo_ok | input | 1 | Positive rail above its undervoltage level |
| pos_reg | input | 1 | Positive rail in regulation |
| chk_fail | input | 1 | Status-check result, high means failed |
| neg_phase_ok | input | 1 | Negative rail beyond the phase threshold |
| neg_uvp_ok | input | 1 | Negative rail past its undervoltage point |
| ramp_en | output | 1 | Power stage switching allowed |
| diag_pulse | output | 1 | One-cycle diagnostic current pulse |
| ipk_sel | output | 2 | Negative-rail peak current: 00 off, 01 low, 10 high |
| pgood | output | 1 | Power good |
| fault | output | 1 | Sticky fault flag |
| shutdown | output | 1 | Restart wait after a fault |

## Verification
The assertions assume that the comparator flags and `chk_fail` are synchronous to `clk` and stable around each rising edge. They also assume at least two cycles since reset before a pulse can be judged against the status check. The stimulus changes every input one time unit after a rising edge. It raises `pos_uvlo_ok`, `pos_reg`, `neg_phase_ok` and `neg_uvp_ok` in the order a real supply would, and it also holds them off to force each timeout. Enable and input-supply loss are applied during the run state and during the restart wait. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_POS_RAMP = 3'd1,
      ST_CHECK    = 3'd2,
      ST_PULSE    = 3'd3,
      ST_POS_WAIT = 3'd4,
      ST_NEG_RAMP = 3'd5,
      ST_RUN      = 3'd6,
      ST_RESTART  = 3'd7
   } seq_state_t;

   typedef enum logic [1:0] {
      IPK_OFF  = 2'b00,
      IPK_LOW  = 2'b01,
      IPK_HIGH = 2'b10
   } ipk_level_t;

endpackage

// File: rtl/seq_cycle_timer.sv
module seq_cycle_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(LIMIT) + 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("seq_cycle_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   // Count while the owning state is active; clear otherwise, so every
   // entry starts from zero. Saturates at the last value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/seq_neg_stage.sv
module seq_neg_stage #(
   parameter bit PHASE_LATCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic phase_in,
   input  logic uvp_in,
   output logic phase_hi,
   output logic uvp_seen
);
   logic uvp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       uvp_q <= 1'b0;
      else if (!active) uvp_q <= 1'b0;
      else if (uvp_in)  uvp_q <= 1'b1;
   end

   assign uvp_seen = uvp_q | uvp_in;

   if (PHASE_LATCH) begin : g_latched
      logic ph_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ph_q <= 1'b0;
         else if (!active)  ph_q <= 1'b0;
         else if (phase_in) ph_q <= 1'b1;
      end
      assign phase_hi = ph_q;
   end else begin : g_live
      assign phase_hi = phase_in;
   end

endmodule

// File: rtl/bias_startup_seq.sv
module bias_startup_seq
   import bias_seq_pkg::*;
#(
   parameter int SS_CYC      = 64,
   parameter int NEG_CYC     = 48,
   parameter int PG_CYC      = 32,
   parameter int RST_CYC     = 40,
   parameter bit PHASE_LATCH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vin_ok,
   input  logic       en,
   input  logic       pos_uvlo_ok,
   input  logic       pos_reg,
   input  logic       chk_fail,
   input  logic       neg_phase_ok,
   input  logic       neg_uvp_ok,
   output logic       ramp_en,
   output logic       diag_pulse,
   output logic [1:0] ipk_sel,
   output logic       pgood,
   output logic       fault,
   output logic       shutdown
);

   if (SS_CYC < 4) begin : g_bad_ss
      $error("bias_startup_seq: SS_CYC must allow check and pulse cycles");
   end
   if (NEG_CYC < 2 || PG_CYC < 2 || RST_CYC < 2) begin : g_bad_tmr
      $error("bias_startup_seq: timer lengths must be at least 2");
   end

   seq_state_t st_q, st_d;
   logic       go;
   logic       in_pos, in_neg, in_rst;
   logic       ss_done, neg_to, pg_done, rst_done;
   logic       ph_hi, uvp_seen;
   logic       fault_q;

   assign go     = vin_ok & en;
   assign in_pos = (st_q == ST_POS_RAMP) || (st_q == ST_CHECK) ||
                   (st_q == ST_PULSE)    || (st_q == ST_POS_WAIT);
   assign in_neg = (st_q == ST_NEG_RAMP);
   assign in_rst = (st_q == ST_RESTART);

   seq_cycle_timer #(.LIMIT(SS_CYC)) i_ss_tmr (
      .clk(clk), .rst_n(rst_n), .run(in_pos), .done(ss_done));
   seq_cycle_timer #(.LIMIT(NEG_CYC)) i_neg_tmr (
      .clk(clk), .rst_n(rst_n), .run(in_neg), .done(neg_to));
   seq_cycle_timer #(.LIMIT(PG_CYC)) i_pg_tmr (
      .clk(clk), .rst_n(rst_n), .run(in_neg), .done(pg_done));
   seq_cycle_timer #(.LIMIT(RST_CYC)) i_rst_tmr (
      .clk(clk), .rst_n(rst_n), .run(in_rst), .done(rst_done));

   seq_neg_stage #(.PHASE_LATCH(PHASE_LATCH)) i_neg_stage (
      .clk(clk), .rst_n(rst_n), .active(in_neg),
      .phase_in(neg_phase_ok), .uvp_in(neg_uvp_ok),
      .phase_hi(ph_hi), .uvp_seen(uvp_seen));

   // Next state: losing enable or input supply overrides everything;
   // the positive timeout overrides progress within the positive ramp.
   always_comb begin
      st_d = st_q;
      if (!go) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:     st_d = ST_POS_RAMP;
            ST_POS_RAMP: if (ss_done)          st_d = ST_RESTART;
                         else if (pos_uvlo_ok) st_d = ST_CHECK;
            ST_CHECK:    if (ss_done || chk_fail) st_d = ST_RESTART;
                         else                     st_d = ST_PULSE;
            ST_PULSE:    if (ss_done) st_d = ST_RESTART;
                         else         st_d = ST_POS_WAIT;
            ST_POS_WAIT: if (ss_done)      st_d = ST_RESTART;
                         else if (pos_reg) st_d = ST_NEG_RAMP;
            ST_NEG_RAMP: if (pg_done && uvp_seen)    st_d = ST_RUN;
                         else if (neg_to && !uvp_seen) st_d = ST_RESTART;
            ST_RUN:      st_d = ST_RUN;
            ST_RESTART:  if (rst_done) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else if (st_d == ST_RESTART && st_q != ST_RESTART) begin
         fault_q <= 1'b1;
      end else if (st_d == ST_POS_RAMP && st_q == ST_IDLE) begin
         fault_q <= 1'b0;
      end
   end

   always_comb begin
      ipk_sel = IPK_OFF;
      if (in_neg)             ipk_sel = ph_hi ? IPK_HIGH : IPK_LOW;
      else if (st_q == ST_RUN) ipk_sel = IPK_HIGH;
   end

   assign ramp_en    = in_pos || in_neg || (st_q == ST_RUN);
   assign diag_pulse = (st_q == ST_PULSE);
   assign pgood      = (st_q == ST_RUN);
   assign fault      = fault_q;
   assign shutdown   = in_rst;

endmodule

// File: rtl/bias_startup_seq_chk.sv
module bias_startup_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vin_ok,
   input logic       en,
   input logic       pos_uvlo_ok,
   input logic       pos_reg,
   input logic       chk_fail,
   input logic       ramp_en,
   input logic       diag_pulse,
   input logic [1:0] ipk_sel,
   input logic       pgood,
   input logic       fault,
   input logic       shutdown
);

   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      diag_pulse |=> !diag_pulse);

   assert_pulse_after_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
      diag_pulse |-> ($past(!chk_fail) && $past(pos_uvlo_ok, 2)));

   assert_neg_after_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ipk_sel == 2'b01 && $past(ipk_sel) == 2'b00) |-> $past(pos_reg));

   assert_enable_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || !vin_ok) |=> (!ramp_en && !pgood && !shutdown));

   assert_pgood_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> ($past(ipk_sel) != 2'b00));

   assert_shutdown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (!ramp_en && ipk_sel == 2'b00));

   assert_fault_on_shutdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |-> fault);

   assert_fault_clear_on_ramp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ramp_en) |-> !fault);

endmodule

bind bias_startup_seq bias_startup_seq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .en(en),
   .pos_uvlo_ok(pos_uvlo_ok), .pos_reg(pos_reg), .chk_fail(chk_fail),
   .ramp_en(ramp_en), .diag_pulse(diag_pulse), .ipk_sel(ipk_sel),
   .pgood(pgood), .fault(fault), .shutdown(shutdown));

// File: tb/test_bias_startup_seq.sv
`timescale 1ns/1ps
module test_bias_startup_seq;
   localparam int SS  = 64;
   localparam int NG  = 48;
   localparam int PG  = 32;
   localparam int RS  = 40;

   localparam int M_IDLE = 0, M_POS = 1, M_CHK = 2, M_PUL = 3,
                  M_WAIT = 4, M_NEG = 5, M_RUN = 6, M_RST = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vin_ok = 0, en = 0, pos_uvlo_ok = 0, pos_reg = 0, chk_fail = 0;
   logic neg_phase_ok = 0, neg_uvp_ok = 0;
   logic ramp_en, diag_pulse, pgood, fault, shutdown;
   logic [1:0] ipk_sel;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bias_startup_seq #(.SS_CYC(SS), .NEG_CYC(NG), .PG_CYC(PG), .RST_CYC(RS))
   i_bias_startup_seq (
      .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .en(en),
      .pos_uvlo_ok(pos_uvlo_ok), .pos_reg(pos_reg), .chk_fail(chk_fail),
      .neg_phase_ok(neg_phase_ok), .neg_uvp_ok(neg_uvp_ok),
      .ramp_en(ramp_en), .diag_pulse(diag_pulse), .ipk_sel(ipk_sel),
      .pgood(pgood), .fault(fault), .shutdown(shutdown));

   // Behavioural reference model
   int m_st = M_IDLE, m_t = 0, m_ph = 0, m_ok = 0, m_flt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = M_IDLE; m_t = 0; m_ph = 0; m_ok = 0; m_flt = 0;
      end else if (!(vin_ok && en)) begin
         m_st = M_IDLE;
      end else begin
         case (m_st)
            M_IDLE: begin m_st = M_POS; m_t = 0; m_flt = 0; end
            M_POS, M_CHK, M_PUL, M_WAIT: begin
               if (m_t >= SS - 1) begin
                  m_st = M_RST; m_t = 0; m_flt = 1;
               end else begin
                  m_t++;
                  if (m_st == M_POS && pos_uvlo_ok) m_st = M_CHK;
                  else if (m_st == M_CHK) begin
                     if (chk_fail) begin m_st = M_RST; m_t = 0; m_flt = 1; end
                     else m_st = M_PUL;
                  end else if (m_st == M_PUL) m_st = M_WAIT;
                  else if (m_st == M_WAIT && pos_reg) begin
                     m_st = M_NEG; m_t = 0; m_ph = 0; m_ok = 0;
                  end
               end
            end
            M_NEG: begin
               if (neg_phase_ok) m_ph = 1;
               if (neg_uvp_ok) m_ok = 1;
               if (m_t >= PG - 1 && m_ok) m_st = M_RUN;
               else if (m_t >= NG - 1 && !m_ok) begin
                  m_st = M_RST; m_t = 0; m_flt = 1;
               end else m_t++;
            end
            M_RST: if (m_t >= RS - 1) m_st = M_IDLE; else m_t++;
            default: ;
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      int e_ipk;
      e_ipk = (m_st == M_NEG) ? (m_ph ? 2 : 1) : (m_st == M_RUN ? 2 : 0);
      chk(ramp_en == (m_st inside {M_POS, M_CHK, M_PUL, M_WAIT, M_NEG, M_RUN}),
          "R1 ramp_en", ramp_en, m_st inside {M_POS, M_CHK, M_PUL, M_WAIT, M_NEG, M_RUN});
      chk(diag_pulse == (m_st == M_PUL), "R3 diag_pulse", diag_pulse, m_st == M_PUL);
      chk(int'(ipk_sel) == e_ipk, "R5 ipk_sel", ipk_sel, e_ipk);
      chk(pgood == (m_st == M_RUN), "R7 pgood", pgood, m_st == M_RUN);
      chk(fault == m_flt[0], "R10 fault", fault, m_flt);
      chk(shutdown == (m_st == M_RST), "R8 shutdown", shutdown, m_st == M_RST);
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      tick(3);
      @(negedge clk);
      chk({ramp_en, diag_pulse, ipk_sel, pgood, fault, shutdown} == 7'd0,
          "R11 reset outputs", {ramp_en, diag_pulse, ipk_sel, pgood, fault, shutdown}, 0);
      tick(1); rst_n = 1;

      // R1: enable without input supply does not start
      en = 1; tick(5); @(negedge clk);
      chk(!ramp_en, "R1 no start without vin", ramp_en, 0);

      // Nominal start-up
      tick(1); vin_ok = 1; tick(1); @(negedge clk);
      chk(ramp_en, "R1 start next cycle", ramp_en, 1);
      tick(4); pos_uvlo_ok = 1; tick(6); pos_reg = 1;
      tick(1); @(negedge clk);
      chk(ipk_sel == 2'b01, "R4 negative ramp low current", ipk_sel, 1);
      tick(7); neg_phase_ok = 1; tick(1); @(negedge clk);
      chk(ipk_sel == 2'b10, "R5 high current after phase", ipk_sel, 2);
      tick(5); neg_uvp_ok = 1; tick(40); @(negedge clk);
      chk(pgood, "R7 power good", pgood, 1);
      en = 0; tick(1); @(negedge clk);
      chk(!pgood && !shutdown, "R9 enable loss clears pgood", pgood, 0);
      pos_uvlo_ok = 0; pos_reg = 0; neg_phase_ok = 0; neg_uvp_ok = 0;
      tick(2);

      // R2 and R8: positive timeout and hiccup
      en = 1; tick(SS + 3); @(negedge clk);
      chk(shutdown && fault, "R2 positive timeout shutdown", shutdown, 1);
      tick(RS + 1); @(negedge clk);
      chk(ramp_en && !fault, "R8 restart attempt", ramp_en, 1);
      tick(SS); @(negedge clk);
      chk(shutdown && fault, "R8 hiccup repeats", shutdown, 1);
      en = 0; tick(1); @(negedge clk);
      chk(!shutdown && fault, "R9 idle with sticky fault", shutdown, 0);
      tick(3); @(negedge clk);
      chk(fault, "R10 fault held in idle", fault, 1);

      // R3: failing status check
      chk_fail = 1; pos_uvlo_ok = 1; en = 1; tick(4); @(negedge clk);
      chk(shutdown, "R3 check failure shuts down", shutdown, 1);
      en = 0; chk_fail = 0; tick(2);

      // R6: negative-rail timeout
      pos_reg = 1; en = 1; tick(6); @(negedge clk);
      chk(ipk_sel == 2'b01 && !fault, "R6 negative ramp running", ipk_sel, 1);
      tick(50); @(negedge clk);
      chk(shutdown && fault, "R6 negative timeout", shutdown, 1);

      // R9: input loss during restart wait
      vin_ok = 0; tick(1); @(negedge clk);
      chk(!shutdown && !ramp_en, "R9 vin loss in restart", shutdown, 0);
      tick(4);
      finish_run();
   end
endmodule